// File: doc/BRIEF.md
# Programmable Dual-Phase Clock Divider

This block derives two slow clocks from one fast clock. A free-running period counter steps from 0 up to a programmable limit D and then returns to 0, so every derived period lasts D+1 fast cycles. Each of the two outputs carries its own pair of edge positions, a count at which it goes high and a count at which it goes low. Software can therefore place the outputs anywhere within the period: in phase, in quadrature, or at any other offset and duty cycle.

New settings are presented on the input buses together with a one-cycle update strobe. The block copies them into a shadow set and holds them until the current period ends. The shadow set becomes active only at the wrap back to count 0, so a period never mixes old and new settings. A two-state update machine tracks whether a shadow set is waiting. In `ST_RUN` nothing is waiting. A strobe that does not fall on the wrap cycle moves it to `ST_PEND`. In `ST_PEND` a later strobe overwrites the shadow and the machine stays put. The wrap returns it to `ST_RUN`, and the pending values are applied at that same wrap.

Top module: `clkdiv_dual_phase`

## Requirements
- R1: With an active divide value D greater than 0, the period counter runs 0, 1, …, D and then returns to 0, so each output repeats every D+1 input cycles.
- R2: In a phase word, bits [7:0] hold the rise count and bits [15:8] hold the fall count. An output is high in the cycle in which the counter equals its rise count and low in the cycle in which it equals its fall count. In every other cycle the output keeps its previous level.
- R3: After reset the divide value is 7. Output 0 rises at count 0 and falls at count 4. Output 1 rises at count 2 and falls at count 6.
- R4: When the update strobe is high in a cycle that is not the last count of the period, the bus values are held in a shadow set. The current period finishes with the old settings, and the new settings take effect from count 0 of the next period.
- R5: When the update strobe is high in the last-count cycle, the bus values take effect directly from the following count 0. Among several strobes inside one period, the last one wins.
- R6: When an output's rise and fall counts are equal and D is not 0, that output stays low.
- R7: An edge count greater than D never matches the counter, so that edge never happens and the output keeps its level.
- R8: While the active-low reset is low, the counter is 0 and both outputs are low.
- R9: When the active divide value is 0, the edge comparison is bypassed and both outputs are high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_set | input | 8 | Requested divide value D (period = D+1) |
| phase0_set | input | 16 | Requested edges of output 0: [7:0] rise, [15:8] fall |
| phase1_set | input | 16 | Requested edges of output 1: [7:0] rise, [15:8] fall |
| upd_stb | input | 1 | One-cycle strobe to take up the requested settings |
| clk_out0 | output | 1 | Derived clock 0 |
| clk_out1 | output | 1 | Derived clock 1 |

## Verification
The update strobe can land in the very cycle in which the period counter wraps. In that cycle, capturing into the shadow and applying to the active set happen at once, and the wrap must take the values on the bus rather than the stale shadow. The bench follows its own model of the counter, waits until that model is at the last count, and raises the strobe for exactly that cycle. It then compares both outputs every cycle with the expected waveform of the new settings starting from count 0. A second case places two strobes inside one period to confirm that the later one is the one applied.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_PEND = 1'b1
    } upd_state_e;
endpackage

// File: rtl/cdiv_settings.sv
module cdiv_settings
    import cdiv_pkg::*;
#(
    parameter int W    = 8,
    parameter int NOUT = 2,
    parameter logic [W-1:0] DEF_DIV = W'(7),
    parameter logic [NOUT-1:0][2*W-1:0] DEF_PH = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       upd_stb,
    input  logic                       wrap,
    input  logic [W-1:0]               div_in,
    input  logic [NOUT-1:0][2*W-1:0]   ph_in,
    output logic [W-1:0]               div_act,
    output logic [NOUT-1:0][2*W-1:0]   ph_act,
    output logic [W-1:0]               div_nxt,
    output logic [NOUT-1:0][2*W-1:0]   ph_nxt
);
    upd_state_e state, state_nxt;
    logic [W-1:0]             div_sh;
    logic [NOUT-1:0][2*W-1:0] ph_sh;
    logic apply, load_sh;

    // next-state and control decode
    always_comb begin
        state_nxt = state;
        load_sh   = 1'b0;
        apply     = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (upd_stb && !wrap) begin
                    state_nxt = ST_PEND;
                    load_sh   = 1'b1;
                end else if (upd_stb && wrap) begin
                    apply     = 1'b1;
                end
            end
            ST_PEND: begin
                if (wrap) begin
                    state_nxt = ST_RUN;
                    apply     = 1'b1;
                end else if (upd_stb) begin
                    load_sh   = 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        div_nxt = div_act;
        ph_nxt  = ph_act;
        if (apply) begin
            div_nxt = upd_stb ? div_in : div_sh;
            ph_nxt  = upd_stb ? ph_in  : ph_sh;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    // shadow and active settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_sh  <= DEF_DIV;
            ph_sh   <= DEF_PH;
            div_act <= DEF_DIV;
            ph_act  <= DEF_PH;
        end else begin
            if (load_sh) begin
                div_sh <= div_in;
                ph_sh  <= ph_in;
            end
            div_act <= div_nxt;
            ph_act  <= ph_nxt;
        end
    end
endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div_act,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output logic         wrap
);
    always_comb begin
        wrap    = (cnt == div_act);
        cnt_nxt = wrap ? '0 : cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end
endmodule

// File: rtl/cdiv_edge.sv
module cdiv_edge #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   cnt_nxt,
    input  logic [W-1:0]   div_nxt,
    input  logic [2*W-1:0] ph_nxt,
    output logic           clk_o
);
    logic [W-1:0] rise_at, fall_at;
    logic         lvl_nxt;

    always_comb begin
        rise_at = ph_nxt[W-1:0];
        fall_at = ph_nxt[2*W-1:W];
        lvl_nxt = clk_o;
        if (div_nxt == '0)            lvl_nxt = 1'b1;
        else if (rise_at == fall_at)  lvl_nxt = 1'b0;
        else if (cnt_nxt == rise_at)  lvl_nxt = 1'b1;
        else if (cnt_nxt == fall_at)  lvl_nxt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_o <= 1'b0;
        else        clk_o <= lvl_nxt;
    end
endmodule

// File: rtl/clkdiv_dual_phase.sv
module clkdiv_dual_phase #(
    parameter int W = 8,
    parameter logic [W-1:0] DEF_DIV = W'(7)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div_set,
    input  logic [2*W-1:0] phase0_set,
    input  logic [2*W-1:0] phase1_set,
    input  logic         upd_stb,
    output logic         clk_out0,
    output logic         clk_out1
);
    localparam int NOUT   = 2;
    localparam int PERIOD = int'(DEF_DIV) + 1;
    localparam logic [W-1:0] RISE0 = '0;
    localparam logic [W-1:0] FALL0 = W'(PERIOD >> 1);
    localparam logic [W-1:0] RISE1 = W'(PERIOD >> 2);
    localparam logic [W-1:0] FALL1 = W'((PERIOD >> 2) + (PERIOD >> 1));
    localparam logic [NOUT-1:0][2*W-1:0] DEF_PH = {{FALL1, RISE1}, {FALL0, RISE0}};

    logic [NOUT-1:0][2*W-1:0] ph_in, ph_act, ph_nxt;
    logic [W-1:0] div_act, div_nxt, cnt, cnt_nxt;
    logic         wrap;
    logic [NOUT-1:0] clk_vec;

    assign ph_in = {phase1_set, phase0_set};

    cdiv_settings #(.W(W), .NOUT(NOUT), .DEF_DIV(DEF_DIV), .DEF_PH(DEF_PH)) u_set (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .wrap(wrap),
        .div_in(div_set), .ph_in(ph_in),
        .div_act(div_act), .ph_act(ph_act),
        .div_nxt(div_nxt), .ph_nxt(ph_nxt)
    );

    cdiv_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .div_act(div_act),
        .cnt(cnt), .cnt_nxt(cnt_nxt), .wrap(wrap)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        cdiv_edge #(.W(W)) u_edge (
            .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt),
            .div_nxt(div_nxt), .ph_nxt(ph_nxt[g]), .clk_o(clk_vec[g])
        );
    end

    assign clk_out0 = clk_vec[0];
    assign clk_out1 = clk_vec[1];
endmodule

// File: rtl/cdiv_checker.sv
module cdiv_checker #(
    parameter int W    = 8,
    parameter int NOUT = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [W-1:0]             cnt,
    input logic [W-1:0]             div_act,
    input logic [NOUT-1:0][2*W-1:0] ph_act,
    input logic [NOUT-1:0]          clk_vec
);
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= div_act); // R1
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == div_act) |=> (cnt == '0)); // R1
    AST_DIV_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_act) |-> (cnt == '0)); // R4
    AST_PHASE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ph_act) |-> (cnt == '0)); // R4
    AST_BYPASS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && div_act == '0) |-> (&clk_vec)); // R9

    for (genvar g = 0; g < NOUT; g++) begin : g_chk
        AST_EQUAL_EDGES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (div_act != '0 && ph_act[g][W-1:0] == ph_act[g][2*W-1:W]) |-> !clk_vec[g]); // R6
        AST_HIGH_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && div_act != '0 && cnt == ph_act[g][W-1:0]
             && ph_act[g][W-1:0] != ph_act[g][2*W-1:W]) |-> clk_vec[g]); // R2
        AST_LOW_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && div_act != '0 && cnt == ph_act[g][2*W-1:W]) |-> !clk_vec[g]); // R2
    end
endmodule

bind clkdiv_dual_phase cdiv_checker #(.W(W), .NOUT(2)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .div_act(div_act),
    .ph_act(ph_act), .clk_vec(clk_vec)
);

// File: tb/tb_clkdiv_dual_phase.sv
module tb_clkdiv_dual_phase;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  div_set = 8'd7;
    logic [15:0] phase0_set = 16'h0;
    logic [15:0] phase1_set = 16'h0;
    logic upd_stb = 1'b0;
    logic clk_out0, clk_out1;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R3";

    typedef struct packed { logic o0; logic o1; } exp_t;
    exp_t q[$];

    // reference model state (from requirements)
    logic [7:0] mcnt, mdiv, mr0, mf0, mr1, mf1;
    logic [7:0] sdiv, sr0, sf0, sr1, sf1;
    logic mpend, mo0, mo1;

    clkdiv_dual_phase dut (
        .clk(clk), .rst_n(rst_n), .div_set(div_set),
        .phase0_set(phase0_set), .phase1_set(phase1_set),
        .upd_stb(upd_stb), .clk_out0(clk_out0), .clk_out1(clk_out1)
    );

    always #10 clk = ~clk;

    function automatic logic next_lvl(logic cur, logic [7:0] c, logic [7:0] d,
                                      logic [7:0] r, logic [7:0] f);
        if (d == 0)      return 1'b1;
        if (r == f)      return 1'b0;
        if (c == r)      return 1'b1;
        if (c == f)      return 1'b0;
        return cur;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcnt = 0; mdiv = 7; mr0 = 0; mf0 = 4; mr1 = 2; mf1 = 6;
            sdiv = 7; sr0 = 0; sf0 = 4; sr1 = 2; sf1 = 6;
            mpend = 0; mo0 = 0; mo1 = 0;
            q.delete();
        end else begin
            if (mcnt == mdiv) begin
                mcnt = 0;
                if (upd_stb) begin
                    mdiv = div_set; mr0 = phase0_set[7:0]; mf0 = phase0_set[15:8];
                    mr1 = phase1_set[7:0]; mf1 = phase1_set[15:8];
                end else if (mpend) begin
                    mdiv = sdiv; mr0 = sr0; mf0 = sf0; mr1 = sr1; mf1 = sf1;
                end
                mpend = 0;
            end else begin
                mcnt = mcnt + 1;
                if (upd_stb) begin
                    sdiv = div_set; sr0 = phase0_set[7:0]; sf0 = phase0_set[15:8];
                    sr1 = phase1_set[7:0]; sf1 = phase1_set[15:8];
                    mpend = 1;
                end
            end
            mo0 = next_lvl(mo0, mcnt, mdiv, mr0, mf0);
            mo1 = next_lvl(mo1, mcnt, mdiv, mr1, mf1);
            q.push_back('{o0: mo0, o1: mo1});
        end
    end

    // monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            n_chk++;
            if (clk_out0 !== 1'b0 || clk_out1 !== 1'b0) begin
                n_bad++;
                $display("FAIL R8 reset outputs actual=%b%b expected=00", clk_out0, clk_out1);
            end
        end else if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (clk_out0 !== e.o0 || clk_out1 !== e.o1) begin
                n_bad++;
                $display("FAIL %s out0,out1 actual=%b%b expected=%b%b at %0t",
                         cur_req, clk_out0, clk_out1, e.o0, e.o1, $time);
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic upd(logic [7:0] d, logic [15:0] p0, logic [15:0] p1);
        @(negedge clk); #2;
        div_set = d; phase0_set = p0; phase1_set = p1; upd_stb = 1'b1;
        @(negedge clk); #2;
        upd_stb = 1'b0;
    endtask

    task automatic upd_at_wrap(logic [7:0] d, logic [15:0] p0, logic [15:0] p1);
        @(negedge clk);
        while (mcnt != mdiv) @(negedge clk);
        #2;
        div_set = d; phase0_set = p0; phase1_set = p1; upd_stb = 1'b1;
        @(negedge clk); #2;
        upd_stb = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R8";
        wait_cyc(4);
        rst_n = 1'b1;
        cur_req = "R3";
        wait_cyc(24);
        cur_req = "R1";
        wait_cyc(8);
        // R4: mid-period strobe, D=5, out0 1..4, out1 rises 3 falls 0
        cur_req = "R4";
        wait_cyc(3);
        upd(8'd5, {8'd4, 8'd1}, {8'd0, 8'd3});
        wait_cyc(20);
        // R2: quadrature-like placement with D=9
        cur_req = "R2";
        upd(8'd9, {8'd5, 8'd0}, {8'd7, 8'd2});
        wait_cyc(30);
        // R5: strobe exactly on the last count
        cur_req = "R5";
        upd_at_wrap(8'd3, {8'd2, 8'd0}, {8'd3, 8'd1});
        wait_cyc(12);
        // R5: two strobes in one period, last wins
        upd(8'd6, {8'd1, 8'd5}, {8'd2, 8'd4});
        upd(8'd4, {8'd3, 8'd1}, {8'd4, 8'd2});
        wait_cyc(20);
        // R6: equal edges hold low
        cur_req = "R6";
        upd(8'd5, {8'd2, 8'd2}, {8'd3, 8'd0});
        wait_cyc(20);
        // R7: edges beyond D never occur
        cur_req = "R7";
        upd(8'd5, {8'd3, 8'd9}, {8'd200, 8'd2});
        wait_cyc(24);
        // R9: bypass with D=0
        cur_req = "R9";
        upd(8'd0, {8'd1, 8'd0}, {8'd2, 8'd1});
        wait_cyc(12);
        cur_req = "R1";
        upd(8'd2, {8'd1, 8'd0}, {8'd2, 8'd1});
        wait_cyc(15);
        // R8: reset in the middle of operation
        cur_req = "R8";
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        cur_req = "R3";
        wait_cyc(20);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule